// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small stored-program computer built around a single 16-bit accumulator. It runs every instruction in three phases. Fetch reads the word at the program counter. Decode latches that word into the instruction register and advances the program counter. Execute performs the operation. All traffic goes over one single-port memory that sits outside the block. The memory answers a read a fixed number of cycles after the request, and that number is set by a parameter.

An instruction word has a 2-bit operation code in its top two bits and a 14-bit direct address below it. There are four operations: load the accumulator from memory, store the accumulator to memory, add a memory word to the accumulator, and branch when the accumulator is negative. The branch is the only control flow, which is enough to run a repeated-addition multiply loop.

The memory address always comes from a dedicated address register. Read data arrives in an inbound buffer register, and write data leaves from an outbound buffer register. A halt request parks the machine between instructions. While it is parked, the program counter and the accumulator can be read on the debug outputs. Releasing the request resumes execution, so the request can also be used to single-step.

Top module: `accCpu`

## Requirements
- R1: While reset is held, the program counter and accumulator read 0 on the debug outputs, and chip select and write enable are low.
- R2: An instruction word carries its operation code in bits 15:14 and its operand address in bits 13:0. Code 00 (load) replaces the accumulator with the addressed memory word.
- R3: Code 01 (store) writes the accumulator into the addressed memory word and leaves the accumulator unchanged.
- R4: Code 10 (add) sets the accumulator to the accumulator plus the addressed word, modulo 2^16, discarding any carry.
- R5: Code 11 (branch) loads the program counter with the address field when accumulator bit 15 is 1. Otherwise execution continues at the next word.
- R6: Each instruction is read from the address held in the program counter, and the program counter then advances by exactly one.
- R7: Every memory access raises chip select for exactly one cycle. Read data is taken MEM_LAT cycles after the request cycle.
- R8: Write enable is high only together with chip select. The outgoing data stays unchanged in the cycle after chip select drops at the end of a write.
- R9: When the halt request is high at an instruction boundary, the block stops before the next fetch, raises halted, and makes no memory access. The debug program counter then shows the next instruction's address. Clearing the request resumes execution from that address.
- R10: The repeated-addition multiply program, with X at word 40, Y at word 41, -1 at word 42, the product at word 43 and code from word 44, leaves X*Y modulo 2^16 in word 43 for any Y from 0 to 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| haltReq | input | 1 | Park the machine at the next instruction boundary |
| memAddr | output | ADDR_W | Memory word address, taken from the address register |
| memCs | output | 1 | Memory chip select, one cycle per access |
| memWe | output | 1 | Memory write enable, only with chip select |
| memWdata | output | DATA_W | Write data from the outbound buffer register |
| memRdata | input | DATA_W | Read data, valid MEM_LAT cycles after the request |
| halted | output | 1 | High while parked by the halt request |
| dbgPc | output | ADDR_W | Current program counter |
| dbgAcc | output | DATA_W | Current accumulator |

## Verification
The bench single-steps a short load, add, store and branch program across operand pairs chosen at the edges of the arithmetic. These include 0x7FFF+1 landing exactly on 0x8000, 0xFFFF+1 wrapping to zero, and sums that sit on either side of the sign bit. A design that kept the carry would fail the add checks, and a design that tested the wrong bit would branch the wrong way. The multiply program runs over a grid that includes Y=0, a negative X and a product that overflows. Exiting the loop one pass early or late, or losing the wrap, shows up directly in the product word. The bench also halts the machine in the middle of a run and then resumes it. A design that fetched while parked, or that skipped or repeated an instruction on resume, would either issue a chip select while halted or give the wrong product. A monitor watches every write for data that changes as chip select falls and for a chip select that lasts more than one cycle.

// File: rtl/accCpuPkg.sv
package accCpuPkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_BRN   = 2'b11
  } opCodeE;

  // strobes from the sequencer to the datapath and the memory pins
  typedef struct packed {
    logic marFromPc;
    logic marLoad;
    logic mbrInLoad;
    logic mbrOutLoad;
    logic irLoad;
    logic pcInc;
    logic pcLoad;
    logic accLoad;
    logic accAdd;
    logic memCs;
    logic memWe;
  } ctrlStrobeS;

  typedef enum logic [3:0] {
    S_HALT,
    S_FETCH_ADDR,
    S_FETCH_REQ,
    S_FETCH_WAIT,
    S_DECODE,
    S_EXEC_ADDR,
    S_EXEC_REQ,
    S_EXEC_WAIT,
    S_EXEC_ALU,
    S_EXEC_WRITE,
    S_EXEC_RELEASE
  } seqStateE;

endpackage

// File: rtl/accCpuSeq.sv
module accCpuSeq
  import accCpuPkg::*;
#(
  parameter int MEM_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  opCodeE     opCode,
  input  logic       accNeg,
  output ctrlStrobeS strobe,
  output logic       halted
);

  localparam int CNT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(MEM_LAT - 1);

  seqStateE state;
  seqStateE stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic waitDone;
  logic inWait;

  assign inWait   = (state == S_FETCH_WAIT) || (state == S_EXEC_WAIT);
  assign waitDone = (waitCnt == LAST_WAIT);
  assign halted   = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_FETCH_ADDR;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= inWait ? waitCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_HALT: begin
        if (!haltReq) stateNext = S_FETCH_ADDR;
      end
      S_FETCH_ADDR: begin
        if (haltReq) begin
          stateNext = S_HALT;
        end else begin
          strobe.marFromPc = 1'b1;
          strobe.marLoad   = 1'b1;
          stateNext        = S_FETCH_REQ;
        end
      end
      S_FETCH_REQ: begin
        strobe.memCs = 1'b1;
        stateNext    = S_FETCH_WAIT;
      end
      S_FETCH_WAIT: begin
        if (waitDone) begin
          strobe.mbrInLoad = 1'b1;
          stateNext        = S_DECODE;
        end
      end
      S_DECODE: begin
        strobe.irLoad = 1'b1;
        strobe.pcInc  = 1'b1;
        stateNext     = S_EXEC_ADDR;
      end
      S_EXEC_ADDR: begin
        unique case (opCode)
          OP_BRN: begin
            strobe.pcLoad = accNeg;
            stateNext     = S_FETCH_ADDR;
          end
          OP_STORE: begin
            strobe.marLoad    = 1'b1;
            strobe.mbrOutLoad = 1'b1;
            stateNext         = S_EXEC_WRITE;
          end
          default: begin
            strobe.marLoad = 1'b1;
            stateNext      = S_EXEC_REQ;
          end
        endcase
      end
      S_EXEC_REQ: begin
        strobe.memCs = 1'b1;
        stateNext    = S_EXEC_WAIT;
      end
      S_EXEC_WAIT: begin
        if (waitDone) begin
          strobe.mbrInLoad = 1'b1;
          stateNext        = S_EXEC_ALU;
        end
      end
      S_EXEC_ALU: begin
        strobe.accLoad = 1'b1;
        strobe.accAdd  = (opCode == OP_ADD);
        stateNext      = S_FETCH_ADDR;
      end
      S_EXEC_WRITE: begin
        strobe.memCs = 1'b1;
        strobe.memWe = 1'b1;
        stateNext    = S_EXEC_RELEASE;
      end
      S_EXEC_RELEASE: begin
        // select is already low here; the outbound buffer keeps driving
        stateNext = S_FETCH_ADDR;
      end
      default: stateNext = S_FETCH_ADDR;
    endcase
  end

  assert_we_with_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWe |-> strobe.memCs);

  assert_cs_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memCs |=> !strobe.memCs);

  assert_halt_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !strobe.memCs);

  assert_brn_sign_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pcLoad |-> accNeg);

endmodule

// File: rtl/accCpuPath.sv
module accCpuPath
  import accCpuPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeS        strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output opCodeE            opCode,
  output logic              accNeg,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut
);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] mbrIn;
  logic [DATA_W-1:0] mbrOut;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] accNext;
  logic [ADDR_W-1:0] operandAddr;
  logic [ADDR_W-1:0] marNext;

  assign operandAddr = ir[ADDR_W-1:0];
  assign opCode      = opCodeE'(ir[DATA_W-1 -: 2]);
  assign accNeg      = acc[DATA_W-1];
  assign marNext     = strobe.marFromPc ? pc : operandAddr;
  assign accNext     = strobe.accAdd ? acc + mbrIn : mbrIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      mar    <= '0;
      ir     <= '0;
      mbrIn  <= '0;
      mbrOut <= '0;
      acc    <= '0;
    end else begin
      if (strobe.marLoad)    mar    <= marNext;
      if (strobe.mbrInLoad)  mbrIn  <= memRdata;
      if (strobe.mbrOutLoad) mbrOut <= acc;
      if (strobe.irLoad)     ir     <= mbrIn;
      if (strobe.accLoad)    acc    <= accNext;
      if (strobe.pcLoad)      pc <= operandAddr;
      else if (strobe.pcInc)  pc <= pc + 1'b1;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbrOut;
  assign pcOut    = pc;
  assign accOut   = acc;

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.pcInc) |-> pc == ADDR_W'($past(pc) + 1'b1));

  assert_brn_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.pcLoad) |-> pc == $past(operandAddr));

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.accLoad) |-> $stable(acc));

  assert_wdata_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.memCs && strobe.memWe) && !strobe.memCs) |-> $stable(memWdata));

endmodule

// File: rtl/accCpu.sv
module accCpu
  import accCpuPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = DATA_W - 2,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgAcc
);

  ctrlStrobeS strobe;
  opCodeE     opCode;
  logic       accNeg;

  accCpuSeq #(.MEM_LAT(MEM_LAT)) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .haltReq (haltReq),
    .opCode  (opCode),
    .accNeg  (accNeg),
    .strobe  (strobe),
    .halted  (halted)
  );

  accCpuPath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opCode   (opCode),
    .accNeg   (accNeg),
    .pcOut    (dbgPc),
    .accOut   (dbgAcc)
  );

  assign memCs = strobe.memCs;
  assign memWe = strobe.memWe;

endmodule

// File: tb/accCpu_bench.sv
`timescale 1ns/1ps
module accCpu_bench;
  localparam int DW  = 16;
  localparam int AW  = 14;
  localparam int LAT = 2;

  localparam logic [15:0] A_VALS [10] = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFF, 16'h8000,
                                          16'h1234, 16'hFFFF, 16'h0005, 16'h00FF, 16'h4000};
  localparam logic [15:0] B_VALS [10] = '{16'h0000, 16'h0002, 16'h0001, 16'h0001, 16'h8000,
                                          16'h4321, 16'hFFFF, 16'hFFFA, 16'h0F01, 16'h4000};
  localparam logic [15:0] X_VALS [7]  = '{16'h0000, 16'h0001, 16'h0003, 16'h0007,
                                          16'hFFFD, 16'h1234, 16'h7FFF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b1;
  logic [AW-1:0] memAddr;
  logic memCs, memWe, halted;
  logic [DW-1:0] memWdata, memRdata, dbgAcc;
  logic [AW-1:0] dbgPc;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [DW-1:0] ram [256];
  logic [DW-1:0] rdPipe [LAT];
  logic loadEn = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;

  always #2.5 clk = ~clk;

  accCpu #(.DATA_W(DW), .ADDR_W(AW), .MEM_LAT(LAT)) u_accCpu (
    .clk(clk), .rstN(rstN), .haltReq(haltReq),
    .memAddr(memAddr), .memCs(memCs), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .halted(halted), .dbgPc(dbgPc), .dbgAcc(dbgAcc)
  );

  // memory model: fixed read latency of LAT cycles after the select edge
  always @(posedge clk) begin
    if (loadEn) ram[loadAddr] <= loadData;
    else if (memCs && memWe) ram[memAddr[7:0]] <= memWdata;
    if (memCs && !memWe) rdPipe[0] <= ram[memAddr[7:0]];
    for (int k = 1; k < LAT; k++) rdPipe[k] <= rdPipe[k-1];
  end
  assign memRdata = rdPipe[LAT-1];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // bus protocol monitor (R7, R8)
  logic prevCs = 1'b0;
  logic prevWe = 1'b0;
  logic [DW-1:0] prevWdata = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe && !memCs) chk(1'b0, "R8 write enable without select", memWe, 0);
      if (prevCs && memCs) chk(1'b0, "R7 select held two cycles", 1, 0);
      if (prevCs && prevWe && !memCs)
        chk(memWdata == prevWdata, "R8 write data held after select drops", memWdata, prevWdata);
    end
    prevCs = memCs;
    prevWe = memWe;
    prevWdata = memWdata;
  end

  task automatic poke(input logic [7:0] a, input logic [DW-1:0] d);
    loadEn = 1'b1;
    loadAddr = a;
    loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic enterReset(input bit holdHalt);
    @(negedge clk);
    rstN = 1'b0;
    haltReq = holdHalt;
    @(negedge clk);
  endtask

  task automatic leaveReset();
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitHalted(input string req);
    int n = 0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(halted, req, halted, 1);
  endtask

  // run one instruction from the parked state, checking the fetch address (R6)
  task automatic stepOne();
    logic [AW-1:0] pcBefore;
    int n = 0;
    pcBefore = dbgPc;
    haltReq = 1'b0;
    @(negedge clk);
    while (!memCs && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(memAddr == pcBefore, "R6 fetch uses program counter", memAddr, pcBefore);
    haltReq = 1'b1;
    waitHalted("R9 park after single step");
  endtask

  task automatic runToSpin(input int spin);
    int n = 0;
    while (dbgPc != AW'(spin + 1) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(dbgPc == AW'(spin + 1), "R10 program reached final loop", dbgPc, spin + 1);
    haltReq = 1'b1;
    waitHalted("R9 park at end of program");
    chk(dbgPc == AW'(spin), "R9 parked PC shows next instruction", dbgPc, spin);
  endtask

  initial begin
    // R1: reset state with halt held
    rstN = 1'b0;
    haltReq = 1'b1;
    repeat (3) @(negedge clk);
    chk(dbgPc == 0, "R1 reset PC", dbgPc, 0);
    chk(dbgAcc == 0, "R1 reset accumulator", dbgAcc, 0);
    chk(!memCs && !memWe, "R1 reset bus idle", {memCs, memWe}, 0);

    for (int i = 0; i < 256; i++) poke(8'(i), '0);
    // step program: LOAD 100, ADD 101, STORE 102, BRN 0
    poke(8'd0, 16'h0064);
    poke(8'd1, 16'h8065);
    poke(8'd2, 16'h4066);
    poke(8'd3, 16'hC000);
    // multiply program (bootstrap at 0/1 is reloaded later)
    poke(8'd42, 16'hFFFF);
    poke(8'd44, 16'h0029); poke(8'd45, 16'h802A); poke(8'd46, 16'h4029);
    poke(8'd47, 16'hC035); poke(8'd48, 16'h0028); poke(8'd49, 16'h802B);
    poke(8'd50, 16'h402B); poke(8'd51, 16'h002A); poke(8'd52, 16'hC02C);
    poke(8'd53, 16'h002A); poke(8'd54, 16'hC036);

    leaveReset();
    repeat (3) @(negedge clk);
    chk(halted, "R9 halted out of reset with request held", halted, 1);
    chk(dbgPc == 0, "R1 PC still 0 after parked start", dbgPc, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (memCs) seen++;
      end
      chk(seen == 0, "R9 no access while parked", seen, 0);
    end

    // single-step sweep over operand pairs (R2 R3 R4 R5 R6 R7)
    for (int p = 0; p < 10; p++) begin
      logic [15:0] a, b, s;
      a = A_VALS[p];
      b = B_VALS[p];
      s = a + b;
      enterReset(1'b1);
      poke(8'd100, a);
      poke(8'd101, b);
      poke(8'd102, 16'hDEAD);
      leaveReset();
      waitHalted("R9 park before first step");
      stepOne();
      chk(dbgAcc == a, "R2 load copies word", dbgAcc, a);
      chk(dbgPc == 1, "R6 PC advances by one", dbgPc, 1);
      stepOne();
      chk(dbgAcc == s, "R4 add wraps modulo 2^16", dbgAcc, s);
      chk(dbgPc == 2, "R6 PC advances by one", dbgPc, 2);
      stepOne();
      chk(ram[102] == s, "R3 store writes accumulator", ram[102], s);
      chk(dbgAcc == s, "R3 store leaves accumulator", dbgAcc, s);
      stepOne();
      if (s[15]) chk(dbgPc == 0, "R5 branch taken on negative", dbgPc, 0);
      else       chk(dbgPc == 4, "R5 branch falls through", dbgPc, 4);
      chk(dbgAcc == s, "R5 branch leaves accumulator", dbgAcc, s);
    end

    // multiply bootstrap: LOAD 42 (-1), BRN 44
    enterReset(1'b1);
    poke(8'd0, 16'h002A);
    poke(8'd1, 16'hC02C);

    // halt in the middle of a multiply and resume (R9, R10)
    enterReset(1'b0);
    poke(8'd40, 16'd3);
    poke(8'd41, 16'd4);
    poke(8'd43, 16'h0000);
    leaveReset();
    repeat (200) @(negedge clk);
    haltReq = 1'b1;
    waitHalted("R9 park mid-program");
    begin
      logic [AW-1:0] pcHeld;
      logic [DW-1:0] accHeld;
      int seen = 0;
      pcHeld = dbgPc;
      accHeld = dbgAcc;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (memCs) seen++;
      end
      chk(seen == 0, "R9 no access while parked mid-program", seen, 0);
      chk(dbgPc == pcHeld && dbgAcc == accHeld, "R9 state frozen while parked",
          {dbgPc, dbgAcc}, {pcHeld, accHeld});
    end
    haltReq = 1'b0;
    runToSpin(54);
    chk(ram[43] == 16'd12, "R10 product after resume", ram[43], 12);

    // multiply sweep (R10)
    for (int xi = 0; xi < 7; xi++) begin
      for (int y = 0; y < 6; y++) begin
        logic [15:0] x, expP;
        x = X_VALS[xi];
        expP = 16'(32'(x) * 32'(y));
        enterReset(1'b0);
        poke(8'd40, x);
        poke(8'd41, 16'(y));
        poke(8'd43, 16'h0000);
        leaveReset();
        runToSpin(54);
        chk(ram[43] == expP, "R10 product equals X*Y", ram[43], expP);
        chk(ram[41] == 16'hFFFF, "R10 loop count ends at -1", ram[41], 16'hFFFF);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule